// File: doc/BRIEF.md
# DSI burst framer

This block builds the byte sequence of one high-speed burst for a single-lane serial display link. After an accepted start strobe it emits a sync byte and four fixed configuration short packets. It then emits one long pixel-write packet covering a requested number of display lines. The block computes the 6-bit error-correction byte of every packet header itself, so no header table is stored.

Pixel bytes come in on a valid/ready stream and leave on a registered valid/ready output stream, in the same order. The payload is followed by a dummy zero checksum and one extra 0xFF byte. That extra byte guarantees a final data-line transition and is flagged with a last marker. A downstream serializer owns the lane states and timing. Requests whose word count would not fit in the 16-bit length field are refused with a one-cycle error pulse.

Top module: `dsi_burst_framer`

## Requirements
- R1: A start accepted on a clock edge (start_i high, busy_o low, valid line count) raises busy_o after that edge. The first output byte, 0xB8, is presented with out_valid_o high after the following edge.
- R2: After the sync byte come four short packets in this order. Each has identifier 0x15, two data bytes and an ECC byte: 15 29 00 0F, 15 11 00 25, 15 36 80 12, 15 3A 55 02.
- R3: Next comes the long-packet header: 0x39, then the word count low byte, then the word count high byte, then the ECC byte. The word count is lines × 480 + 1.
- R4: The header ECC treats the three header bytes as a 24-bit word with the first byte in bits 7:0. ECC bit k (k = 0..5) is the XOR of the word bits selected by the masks 0xF12CB7, 0xF2555B, 0x749A6D, 0xB8E38E, 0xDF03F0 and 0xEFFC00 respectively. ECC bits 7 and 6 are zero.
- R5: The first payload byte is 0x2C when first_i was high at the accepted start, and 0x3C otherwise.
- R6: Exactly lines × 480 pixel bytes follow, in arrival order. A pixel byte is consumed only on a cycle where both pix_valid_i and pix_ready_o are high, and pix_ready_o is high only while the burst is in its pixel section.
- R7: The burst ends with 0x00, 0x00, 0xFF. out_last_o is high only with the 0xFF byte, and busy_o falls on the cycle after that byte is accepted.
- R8: A start with a line count of 0, or with a count above 136 (word count over 0xFFFF), is refused. err_o is high for the one cycle after that edge, busy_o stays low and no byte is output.
- R9: While out_valid_o is high and out_ready_i is low, out_data_o, out_last_o and out_valid_o hold their values.
- R10: A start strobe while busy_o is high has no effect: the byte stream continues unchanged and err_o stays low.
- R11: During and directly after reset, out_valid_o, busy_o, err_o and pix_ready_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a burst |
| lines_i | input | LINES_W | Number of display lines in the burst |
| first_i | input | 1 | Burst begins a new frame |
| pix_data_i | input | 8 | Pixel byte in |
| pix_valid_i | input | 1 | Pixel byte available |
| pix_ready_o | output | 1 | Pixel byte taken this cycle when valid |
| out_data_o | output | 8 | Burst byte out |
| out_valid_o | output | 1 | Burst byte available |
| out_last_o | output | 1 | Final byte of the burst |
| out_ready_i | input | 1 | Downstream takes the byte |
| busy_o | output | 1 | Burst in progress |
| err_o | output | 1 | Start refused |

## Verification
The error pulse is due one cycle after the refused start edge. The sync byte is due two cycles after an accepted start. Every later byte appears in the output register one cycle after the handshake that freed it, and busy_o drops one cycle after the trailing byte is taken. The bench drives inputs just after the falling edge and samples a short delay later. Each sample therefore shows exactly the state that the next rising edge will act on. Each transferred byte is matched against a queue of expected bytes built from the requirements, whatever the backpressure. The fixed latencies after start and reject are checked at those exact cycles.

// File: rtl/dsi_framer_pkg.sv
package dsi_framer_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SYNC, PH_SHORT, PH_LHDR, PH_SS, PH_PIX, PH_CRC, PH_TAIL
  } phase_t;

  localparam logic [7:0] SYNC_BYTE = 8'hB8;
  localparam logic [7:0] DI_SHORT  = 8'h15;
  localparam logic [7:0] DI_LONG   = 8'h39;
  localparam logic [7:0] SS_FIRST  = 8'h2C;
  localparam logic [7:0] SS_NEXT   = 8'h3C;
  localparam logic [7:0] CRC_BYTE  = 8'h00;
  localparam logic [7:0] TAIL_BYTE = 8'hFF;
  localparam int         NUM_CMDS  = 4;
  localparam int         WC_MAX    = 65535;

  // {param, command} of each configuration short packet, in send order
  function automatic logic [15:0] cfg_cmd(input logic [1:0] idx);
    case (idx)
      2'd0:    cfg_cmd = {8'h00, 8'h29};
      2'd1:    cfg_cmd = {8'h00, 8'h11};
      2'd2:    cfg_cmd = {8'h80, 8'h36};
      default: cfg_cmd = {8'h55, 8'h3A};
    endcase
  endfunction

  function automatic logic [23:0] ecc_mask(input int bitno);
    case (bitno)
      0:       ecc_mask = 24'hF12CB7;
      1:       ecc_mask = 24'hF2555B;
      2:       ecc_mask = 24'h749A6D;
      3:       ecc_mask = 24'hB8E38E;
      4:       ecc_mask = 24'hDF03F0;
      default: ecc_mask = 24'hEFFC00;
    endcase
  endfunction

endpackage

// File: rtl/dsi_hdr_ecc.sv
module dsi_hdr_ecc
  import dsi_framer_pkg::*;
(
  input  logic [23:0] hdr_i,
  output logic [7:0]  ecc_o
);
  localparam int ECC_BITS = 6;

  for (genvar b = 0; b < ECC_BITS; b++) begin : g_par
    assign ecc_o[b] = ^(hdr_i & ecc_mask(b));
  end
  assign ecc_o[7:ECC_BITS] = '0;
endmodule

// File: rtl/dsi_byte_reg.sv
module dsi_byte_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] byte_i,
  input  logic          last_i,
  input  logic          have_i,
  input  logic          ready_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          last_o,
  output logic          load_ok_o
);
  assign load_ok_o = !valid_o || ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      data_o  <= '0;
    end else if (load_ok_o) begin
      valid_o <= have_i;
      if (have_i) begin
        data_o <= byte_i;
        last_o <= last_i;
      end else begin
        last_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dsi_seq_ctrl.sv
module dsi_seq_ctrl
  import dsi_framer_pkg::*;
#(
  parameter int LINE_BYTES = 480,
  parameter int LINES_W    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [LINES_W-1:0] lines_i,
  input  logic               first_i,
  input  logic               busy_i,
  input  logic [7:0]         pix_data_i,
  input  logic               pix_valid_i,
  input  logic               load_ok_i,
  output logic               pix_ready_o,
  output logic [7:0]         nxt_byte_o,
  output logic               nxt_last_o,
  output logic               nxt_have_o,
  output logic               active_o,
  output logic               err_o
);
  localparam int PIX_W = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1;
  localparam int CMD_W = $clog2(NUM_CMDS);
  localparam logic [PIX_W-1:0] PIX_END = PIX_W'(LINE_BYTES - 1);
  localparam logic [CMD_W-1:0] CMD_END = CMD_W'(NUM_CMDS - 1);

  phase_t             phase;
  logic [1:0]         sub;
  logic [CMD_W-1:0]   cmd_idx;
  logic [PIX_W-1:0]   pix_cnt;
  logic [LINES_W-1:0] lines_left;
  logic               first_q;
  logic [15:0]        wc_q;

  logic [31:0] wc_full;
  logic        req_ok;
  logic        adv;
  logic [15:0] cmd_word;
  logic [7:0]  ecc_short, ecc_long;

  assign wc_full = 32'(lines_i) * 32'(LINE_BYTES) + 32'd1;
  assign req_ok  = (lines_i != '0) && (wc_full <= 32'(WC_MAX));
  assign cmd_word = cfg_cmd(2'(cmd_idx));

  dsi_hdr_ecc u_ecc_short (.hdr_i({cmd_word, DI_SHORT}), .ecc_o(ecc_short));
  dsi_hdr_ecc u_ecc_long  (.hdr_i({wc_q, DI_LONG}),      .ecc_o(ecc_long));

  always_comb begin
    nxt_byte_o = 8'h00;
    nxt_last_o = 1'b0;
    nxt_have_o = 1'b1;
    case (phase)
      PH_IDLE:  nxt_have_o = 1'b0;
      PH_SYNC:  nxt_byte_o = SYNC_BYTE;
      PH_SHORT: begin
        case (sub)
          2'd0:    nxt_byte_o = DI_SHORT;
          2'd1:    nxt_byte_o = cmd_word[7:0];
          2'd2:    nxt_byte_o = cmd_word[15:8];
          default: nxt_byte_o = ecc_short;
        endcase
      end
      PH_LHDR: begin
        case (sub)
          2'd0:    nxt_byte_o = DI_LONG;
          2'd1:    nxt_byte_o = wc_q[7:0];
          2'd2:    nxt_byte_o = wc_q[15:8];
          default: nxt_byte_o = ecc_long;
        endcase
      end
      PH_SS:  nxt_byte_o = first_q ? SS_FIRST : SS_NEXT;
      PH_PIX: begin
        nxt_byte_o = pix_data_i;
        nxt_have_o = pix_valid_i;
      end
      PH_CRC:  nxt_byte_o = CRC_BYTE;
      default: begin
        nxt_byte_o = TAIL_BYTE;
        nxt_last_o = 1'b1;
      end
    endcase
  end

  assign pix_ready_o = (phase == PH_PIX) && load_ok_i;
  assign adv         = nxt_have_o && load_ok_i;
  assign active_o    = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      sub        <= '0;
      cmd_idx    <= '0;
      pix_cnt    <= '0;
      lines_left <= '0;
      first_q    <= 1'b0;
      wc_q       <= '0;
      err_o      <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start_i && !busy_i) begin
          if (req_ok) begin
            phase      <= PH_SYNC;
            wc_q       <= wc_full[15:0];
            lines_left <= lines_i;
            first_q    <= first_i;
          end else begin
            err_o <= 1'b1;
          end
        end
      end else if (adv) begin
        case (phase)
          PH_SYNC: begin
            phase   <= PH_SHORT;
            sub     <= '0;
            cmd_idx <= '0;
          end
          PH_SHORT: begin
            sub <= sub + 2'd1;
            if (sub == 2'd3) begin
              if (cmd_idx == CMD_END) phase <= PH_LHDR;
              else                    cmd_idx <= cmd_idx + 1'b1;
            end
          end
          PH_LHDR: begin
            sub <= sub + 2'd1;
            if (sub == 2'd3) phase <= PH_SS;
          end
          PH_SS: begin
            phase   <= PH_PIX;
            pix_cnt <= '0;
          end
          PH_PIX: begin
            if (pix_cnt == PIX_END) begin
              pix_cnt <= '0;
              if (lines_left == LINES_W'(1)) begin
                phase <= PH_CRC;
                sub   <= '0;
              end else begin
                lines_left <= lines_left - 1'b1;
              end
            end else begin
              pix_cnt <= pix_cnt + 1'b1;
            end
          end
          PH_CRC: begin
            sub <= sub + 2'd1;
            if (sub == 2'd1) phase <= PH_TAIL;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dsi_burst_framer.sv
module dsi_burst_framer #(
  parameter int LINE_BYTES = 480,
  parameter int LINES_W    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [LINES_W-1:0] lines_i,
  input  logic               first_i,
  input  logic [7:0]         pix_data_i,
  input  logic               pix_valid_i,
  output logic               pix_ready_o,
  output logic [7:0]         out_data_o,
  output logic               out_valid_o,
  output logic               out_last_o,
  input  logic               out_ready_i,
  output logic               busy_o,
  output logic               err_o
);
  logic [7:0] nxt_byte;
  logic       nxt_last, nxt_have, load_ok, seq_active;

  dsi_seq_ctrl #(.LINE_BYTES(LINE_BYTES), .LINES_W(LINES_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .lines_i(lines_i),
    .first_i(first_i), .busy_i(busy_o), .pix_data_i(pix_data_i),
    .pix_valid_i(pix_valid_i), .load_ok_i(load_ok), .pix_ready_o(pix_ready_o),
    .nxt_byte_o(nxt_byte), .nxt_last_o(nxt_last), .nxt_have_o(nxt_have),
    .active_o(seq_active), .err_o(err_o)
  );

  dsi_byte_reg #(.DW(8)) u_out (
    .clk(clk), .rst(rst), .byte_i(nxt_byte), .last_i(nxt_last),
    .have_i(nxt_have), .ready_i(out_ready_i), .data_o(out_data_o),
    .valid_o(out_valid_o), .last_o(out_last_o), .load_ok_o(load_ok)
  );

  assign busy_o = seq_active || out_valid_o;
endmodule

// File: rtl/dsi_framer_checker.sv
module dsi_framer_checker (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       pix_ready_o,
  input logic [7:0] out_data_o,
  input logic       out_valid_o,
  input logic       out_last_o,
  input logic       out_ready_i,
  input logic       busy_o,
  input logic       err_o
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));

  assert_last_tail_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid_o && out_last_o |-> out_data_o == 8'hFF);

  assert_end_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(out_valid_o && out_last_o && out_ready_i));

  assert_err_idle_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !busy_o && !out_valid_o);

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (rst)
    start_i && busy_o |=> !err_o);

  assert_pix_gate_R6: assert property (@(posedge clk) disable iff (rst)
    pix_ready_o |-> busy_o);
endmodule

bind dsi_burst_framer dsi_framer_checker u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .pix_ready_o(pix_ready_o),
  .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_last_o(out_last_o),
  .out_ready_i(out_ready_i), .busy_o(busy_o), .err_o(err_o)
);

// File: tb/sim_dsi_burst_framer.sv
`timescale 1ns/1ps
module sim_dsi_burst_framer;
  localparam int LB = 480;
  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] lines_i = '0;
  logic       first_i = 1'b0;
  logic [7:0] pix_data_i = '0;
  logic       pix_valid_i = 1'b0;
  logic       pix_ready_o;
  logic [7:0] out_data_o;
  logic       out_valid_o, out_last_o;
  logic       out_ready_i = 1'b0;
  logic       busy_o, err_o;

  int checks = 0;
  int errors = 0;
  int pix_idx = 0;
  int cycles = 0;
  bit random_mode = 0;
  bit done = 0;
  logic [8:0] expq[$];
  int         reqq[$];

  always #4 clk = ~clk;

  dsi_burst_framer u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .lines_i(lines_i), .first_i(first_i),
    .pix_data_i(pix_data_i), .pix_valid_i(pix_valid_i), .pix_ready_o(pix_ready_o),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_last_o(out_last_o),
    .out_ready_i(out_ready_i), .busy_o(busy_o), .err_o(err_o)
  );

  function automatic logic [7:0] pix_val(int k);
    return 8'((k * 37 + (k >> 3) + 5) & 255);
  endfunction

  // R4: parity equations written per ECC bit as index lists
  function automatic logic [7:0] ref_ecc(logic [23:0] d);
    logic [7:0] e;
    e = '0;
    e[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
    e[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
    e[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
    e[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
    e[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
    e[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
    return e;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b, bit last, int req);
    expq.push_back({last, b});
    reqq.push_back(req);
  endtask

  task automatic build_expected(int lines, bit first);
    int wc;
    wc = lines * LB + 1;
    push(8'hB8, 0, 1);                                                     // R1
    push(8'h15, 0, 2); push(8'h29, 0, 2); push(8'h00, 0, 2); push(8'h0F, 0, 2); // R2
    push(8'h15, 0, 2); push(8'h11, 0, 2); push(8'h00, 0, 2); push(8'h25, 0, 2);
    push(8'h15, 0, 2); push(8'h36, 0, 2); push(8'h80, 0, 2); push(8'h12, 0, 2);
    push(8'h15, 0, 2); push(8'h3A, 0, 2); push(8'h55, 0, 2); push(8'h02, 0, 2);
    push(8'h39, 0, 3); push(8'(wc), 0, 3); push(8'(wc >> 8), 0, 3);          // R3
    push(ref_ecc({8'(wc >> 8), 8'(wc), 8'h39}), 0, 4);                      // R4
    push(first ? 8'h2C : 8'h3C, 0, 5);                                      // R5
    for (int k = 0; k < lines * LB; k++) push(pix_val(pix_idx + k), 0, 6);  // R6
    push(8'h00, 0, 7); push(8'h00, 0, 7); push(8'hFF, 1, 7);                // R7
  endtask

  // stimulus and beat monitor: drive after falling edge, sample 2 ns later
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      out_ready_i = random_mode ? ($urandom_range(0, 9) < 6) : 1'b1;
      pix_valid_i = random_mode ? ($urandom_range(0, 9) < 7) : 1'b1;
      pix_data_i  = pix_val(pix_idx);
      #2;
      if (!rst) begin
        if (pix_valid_i && pix_ready_o) pix_idx++;
        if (out_valid_o && out_ready_i) begin
          if (expq.size() == 0) begin
            check(0, "R7 unexpected byte", out_data_o, 0);
          end else begin
            logic [8:0] e;
            int r;
            e = expq.pop_front();
            r = reqq.pop_front();
            checks++;
            if ({out_last_o, out_data_o} != e) begin
              errors++;
              $display("FAIL R%0d stream byte actual=%0h expected=%0h", r,
                       {out_last_o, out_data_o}, e);
            end
          end
        end
      end
    end
  end

  task automatic wait_done();
    int n;
    n = 0;
    while ((expq.size() != 0 || busy_o) && n < 150000) begin
      @(negedge clk); #3; n++;
    end
    check(expq.size() == 0 && !busy_o, "R6 burst completion", expq.size(), 0);
  endtask

  task automatic run_burst(int lines, bit first, bit rnd, bit poke_busy);
    random_mode = rnd;
    build_expected(lines, first);
    @(negedge clk);
    start_i = 1'b1; lines_i = 8'(lines); first_i = first;
    @(negedge clk);
    start_i = 1'b0;
    #3;
    check(busy_o && !err_o, "R1 busy after accept", {busy_o, err_o}, 2);
    if (!rnd) begin
      @(negedge clk); #3;
      check(out_valid_o && out_data_o == 8'hB8, "R1 sync byte latency", out_data_o, 8'hB8);
    end
    if (poke_busy) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1; lines_i = 8'd0;        // R10: would be refused if idle
      @(negedge clk);
      start_i = 1'b0;
      #3;
      check(!err_o && busy_o, "R10 start while busy ignored", err_o, 0);
    end
    wait_done();
  endtask

  task automatic reject(int lines);
    @(negedge clk);
    start_i = 1'b1; lines_i = 8'(lines);
    @(negedge clk);
    start_i = 1'b0;
    #3;
    check(err_o && !busy_o, "R8 refused start pulses err", {err_o, busy_o}, 2);
    @(negedge clk); #3;
    check(!err_o && !out_valid_o && !busy_o, "R8 err single cycle, no output",
          {err_o, out_valid_o, busy_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check(!out_valid_o && !busy_o && !err_o && !pix_ready_o, "R11 reset state",
          {out_valid_o, busy_o, err_o, pix_ready_o}, 0);
    rst = 1'b0;
    @(negedge clk); #3;
    check(!out_valid_o && !busy_o && !err_o && !pix_ready_o, "R11 after reset",
          {out_valid_o, busy_o, err_o, pix_ready_o}, 0);

    run_burst(1, 1'b1, 1'b0, 1'b0);   // R1 R2 R3 R5 first frame line
    run_burst(2, 1'b0, 1'b1, 1'b0);   // R9 R6 backpressure, later lines
    run_burst(3, 1'b1, 1'b1, 1'b1);   // R10 start during burst
    reject(0);                        // R8 zero lines
    reject(137);                      // R8 word count over 16 bits
    reject(255);
    run_burst(136, 1'b0, 1'b0, 1'b0); // R3 largest accepted count
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(WATCHDOG * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule